// File: doc/BRIEF.md
# Two-Bank Channel Register File with Serial Slave Access

This block is a two-wire serial bus slave (I2C style) that runs on the system clock. It holds fourteen 8-bit channel values in each of two banks, bank A and bank B. SCL and SDA arrive as oversampled inputs. The block pulls SDA low through an open-drain enable. The slave address has a fixed upper part. Its least significant bit is taken from an input pin, so two of these blocks can share one bus.

A write transfer starts with a control byte, which sets four things:
- which bank later channel bytes go to;
- which bank a later read returns;
- an oscillator-mode flag;
- a lag-mode flag.

The channel bytes that follow fill channels 1 to 14 in turn. A read transfer has no register pointer. It always streams channel 1 onwards from the bank chosen by the last control byte.

Both banks and the latched control fields are available as outputs, where the converters and oscillator logic around the block can use them.

Top module: `chanbank_i2c_slave`

## Requirements
- R1: The block answers only the 7-bit address {111010, addrPin}, which is 0x74 or 0x75. On a match it drives an acknowledge (sdaOe=1) in the ninth clock. Bit 0 of the first byte selects the direction: 0 is a write and 1 is a read.
- R2: The control byte is the first byte after a write address. Bit 0 sets lagSel. Bit 1 sets wrBankSel (0=A, 1=B). Bit 2 sets rdBankSel (0=A, 1=B). Bit 3 sets extOscSel. Bits 7 to 4 are ignored. All four fields reset to 0.
- R3: Each write data byte is acknowledged. The n-th data byte lands in channel n of the bank chosen by wrBankSel, and the other bank is left unchanged. Channel n sits at bits [8n-1:8n-8] of bankAOut or bankBOut.
- R4: A read returns channel 1, 2, ... of the bank chosen by rdBankSel, with the most significant bit first. wrBankSel has no effect on which bank is read.
- R5: After the master sends a not-acknowledge on a read byte, the block stops driving SDA.
- R6: On an address mismatch the block does not acknowledge. It ignores all further bytes until the next START, so the banks and control fields do not change.
- R7: A write byte that arrives after the 14th data byte is not acknowledged and is discarded.
- R8: A STOP in the middle of a write keeps every data byte that was fully received before it. Channels that were not reached keep their old values.
- R9: A repeated START in the middle of a byte abandons that byte without storing it, and the block returns to address reception.
- R10: The control fields change only after all eight bits of the control byte have arrived. A control byte cut short by a STOP leaves them unchanged.
- R11: If the master keeps acknowledging beyond the 14th read byte, every further byte reads as 0xFF and the block does not pull SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line, as sampled from the bus |
| sdaIn | input | 1 | Serial data line, as sampled from the bus |
| addrPin | input | 1 | Address least significant bit |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| bankAOut | output | 112 | Bank A, channel 1 in bits [7:0] |
| bankBOut | output | 112 | Bank B, channel 1 in bits [7:0] |
| wrBankSel | output | 1 | Bank written by data bytes (0=A, 1=B) |
| rdBankSel | output | 1 | Bank returned by reads (0=A, 1=B) |
| extOscSel | output | 1 | Oscillator mode (0=internal, 1=external) |
| lagSel | output | 1 | Lag-mode flag (0=bypass, 1=lagging) |

## Verification
Two pairs of actions share a single SCL falling edge.

In a read, the end of the slave's address acknowledge and the loading of channel 1 into the shifter happen in the same cycle. The bench checks this by doing a read directly after an address acknowledge and comparing the first byte, with channel 1's most significant bit leading, against its scoreboard.

In a write, the commit of a byte and the decision to acknowledge it also happen on the same edge. The bench provokes this with a 15th write byte, expects a not-acknowledge for it, and then checks that channel 1 of the target bank still holds its earlier value.

// File: rtl/i2cbank_pkg.sv
package i2cbank_pkg;
  localparam int NCHAN = 14;
  localparam int IDXW  = $clog2(NCHAN + 2);

  // strobes from the bus controller to the datapath
  typedef struct packed {
    logic            shiftIn;
    logic            rxBit;
    logic            shiftOut;
    logic            loadTx;
    logic            wrCtrl;
    logic            wrChan;
    logic [IDXW-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/i2cbank_dp.sv
module i2cbank_dp
  import i2cbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic [NCHAN*8-1:0] bankAOut,
  output logic [NCHAN*8-1:0] bankBOut,
  output logic              wrBank,
  output logic              rdBank,
  output logic              extOsc,
  output logic              lagMode
);
  logic [7:0] shiftReg;
  logic [7:0] bankQ [2][NCHAN];
  logic [7:0] txByte;

  // byte offered to the shifter: selected bank, or all ones past the end
  always_comb begin
    txByte = 8'hFF;
    for (int c = 0; c < NCHAN; c++)
      if (strb.idx == IDXW'(c)) txByte = rdBank ? bankQ[1][c] : bankQ[0][c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strb.loadTx)   shiftReg <= txByte;
    else if (strb.shiftIn)  shiftReg <= {shiftReg[6:0], strb.rxBit};
    else if (strb.shiftOut) shiftReg <= {shiftReg[6:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lagMode <= 1'b0;
      wrBank  <= 1'b0;
      rdBank  <= 1'b0;
      extOsc  <= 1'b0;
    end else if (strb.wrCtrl) begin
      lagMode <= shiftReg[0];
      wrBank  <= shiftReg[1];
      rdBank  <= shiftReg[2];
      extOsc  <= shiftReg[3];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bankQ[b][c] <= '0;
        else if (strb.wrChan && (wrBank == 1'(b)) && (strb.idx == IDXW'(c)))
          bankQ[b][c] <= shiftReg;
      end
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_flat
    assign bankAOut[c*8 +: 8] = bankQ[0][c];
    assign bankBOut[c*8 +: 8] = bankQ[1][c];
  end

  assign rxByte = shiftReg;
  assign txMsb  = shiftReg[7];
endmodule

// File: rtl/i2cbank_ctrl.sv
module i2cbank_ctrl
  import i2cbank_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b111010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrPin,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output strobe_t    strb,
  output logic       sdaOe,
  output logic       startDet,
  output logic       stopDet
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_WDATA, S_RDATA, S_RACK, S_IGN
  } state_t;

  state_t          state, stateN;
  logic [1:0]      sclSync, sdaSync;
  logic            sclD, sdaD;
  logic [3:0]      bitCnt, bitCntN;
  logic [IDXW-1:0] byteCnt, byteCntN, byteSat;
  logic            isRead, isReadN, mAck, mAckN;
  logic            sclNow, sdaNow, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign sclRise  = sclNow & ~sclD;
  assign sclFall  = ~sclNow & sclD;
  assign startDet = sclNow & sclD & sdaD & ~sdaNow;
  assign stopDet  = sclNow & sclD & ~sdaD & sdaNow;
  assign byteSat  = (byteCnt == IDXW'(NCHAN)) ? byteCnt : byteCnt + 1'b1;

  always_comb begin
    stateN   = state;
    bitCntN  = bitCnt;
    byteCntN = byteCnt;
    isReadN  = isRead;
    mAckN    = mAck;
    strb     = '0;
    if (startDet) begin
      stateN  = S_ADDR;
      bitCntN = 4'd0;
    end else if (stopDet) begin
      stateN = S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            strb.rxBit   = sdaNow;
            bitCntN      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = 4'd0;
            if (state == S_ADDR) begin
              if (rxByte[7:1] == {ADDR_HI, addrPin}) begin
                stateN   = S_ACK;
                isReadN  = rxByte[0];
                byteCntN = '0;
              end else begin
                stateN = S_IGN;
              end
            end else if (byteCnt <= IDXW'(NCHAN)) begin
              stateN   = S_ACK;
              byteCntN = byteCnt + 1'b1;
              if (byteCnt == '0) begin
                strb.wrCtrl = 1'b1;
              end else begin
                strb.wrChan = 1'b1;
                strb.idx    = byteCnt - 1'b1;
              end
            end else begin
              stateN = S_IGN;
            end
          end
        end
        S_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              stateN      = S_RDATA;
              strb.loadTx = 1'b1;
              strb.idx    = byteCnt;
              byteCntN    = byteSat;
            end else begin
              stateN = S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN  = S_RACK;
              bitCntN = 4'd0;
            end else begin
              strb.shiftOut = 1'b1;
              bitCntN       = bitCnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (sclRise) begin
            mAckN = ~sdaNow;
          end else if (sclFall) begin
            if (mAck) begin
              stateN      = S_RDATA;
              strb.loadTx = 1'b1;
              strb.idx    = byteCnt;
              byteCntN    = byteSat;
            end else begin
              stateN = S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      isRead  <= 1'b0;
      mAck    <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      byteCnt <= byteCntN;
      isRead  <= isReadN;
      mAck    <= mAckN;
    end
  end

  assign sdaOe = (state == S_ACK) | ((state == S_RDATA) & ~txMsb);
endmodule

// File: rtl/chanbank_i2c_slave.sv
module chanbank_i2c_slave
  import i2cbank_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b111010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               addrPin,
  output logic               sdaOe,
  output logic [NCHAN*8-1:0] bankAOut,
  output logic [NCHAN*8-1:0] bankBOut,
  output logic               wrBankSel,
  output logic               rdBankSel,
  output logic               extOscSel,
  output logic               lagSel
);
  strobe_t    strb;
  logic [7:0] rxByte;
  logic       txMsb;
  logic       startDet, stopDet;

  i2cbank_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrPin(addrPin),
    .rxByte(rxByte), .txMsb(txMsb), .strb(strb), .sdaOe(sdaOe),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cbank_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .txMsb(txMsb),
    .bankAOut(bankAOut), .bankBOut(bankBOut), .wrBank(wrBankSel),
    .rdBank(rdBankSel), .extOsc(extOscSel), .lagMode(lagSel)
  );
endmodule

// File: rtl/i2cbank_chk.sv
module i2cbank_chk
  import i2cbank_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input strobe_t            strb,
  input logic               sdaOe,
  input logic               startDet,
  input logic               stopDet,
  input logic [NCHAN*8-1:0] bankAOut,
  input logic [NCHAN*8-1:0] bankBOut,
  input logic               wrBankSel,
  input logic               rdBankSel,
  input logic               extOscSel,
  input logic               lagSel
);
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> $stable({wrBankSel, rdBankSel, extOscSel, lagSel}));

  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrChan |=> ($stable(bankAOut) && $stable(bankBOut)));

  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrChan |=> ($stable(bankAOut) || $stable(bankBOut)));

  a_r7_chan_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrChan |-> (strb.idx < IDXW'(NCHAN)));

  a_r9_start_release: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  a_r5_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrChan, strb.loadTx, strb.shiftIn, strb.shiftOut}));
endmodule

bind chanbank_i2c_slave i2cbank_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .sdaOe(sdaOe), .startDet(startDet),
  .stopDet(stopDet), .bankAOut(bankAOut), .bankBOut(bankBOut),
  .wrBankSel(wrBankSel), .rdBankSel(rdBankSel), .extOscSel(extOscSel), .lagSel(lagSel)
);

// File: tb/chanbank_i2c_slave_tb.sv
`timescale 1ns/1ps
module chanbank_i2c_slave_tb;
  localparam int NCH  = 14;
  localparam int QNS  = 50;
  localparam int WDOG = 750000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, addrPin = 1'b0;
  logic sdaLine, sdaOe;
  logic [NCH*8-1:0] bankAOut, bankBOut;
  logic wrBankSel, rdBankSel, extOscSel, lagSel;

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] rdVal;
  event rdEv;

  always #2.5 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  chanbank_i2c_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .addrPin(addrPin),
    .sdaOe(sdaOe), .bankAOut(bankAOut), .bankBOut(bankBOut),
    .wrBankSel(wrBankSel), .rdBankSel(rdBankSel), .extOscSel(extOscSel), .lagSel(lagSel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] chA(input int n);
    return bankAOut[(n-1)*8 +: 8];
  endfunction
  function automatic logic [7:0] chB(input int n);
    return bankBOut[(n-1)*8 +: 8];
  endfunction

  task automatic busStart();
    mSda = 1; #QNS; mScl = 1; #QNS; mSda = 0; #QNS; mScl = 0; #QNS;
  endtask
  task automatic busStop();
    mSda = 0; #QNS; mScl = 1; #QNS; mSda = 1; #QNS;
  endtask
  task automatic sendBit(input logic b);
    mSda = b; #QNS; mScl = 1; #(2*QNS); mScl = 0; #QNS;
  endtask
  task automatic getBit(output logic b);
    mSda = 1; #QNS; mScl = 1; #QNS; b = sdaLine; #QNS; mScl = 0; #QNS;
  endtask
  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask
  task automatic recvByte(input logic nack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    rdVal = v;
    -> rdEv;
    sendBit(nack);
  endtask
  task automatic expectByte(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor: compares each byte read against the queue
  initial begin
    forever begin
      logic [7:0] e;
      string t;
      @(rdEv);
      if (expQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL R4 unexpected read byte actual=%0h expected=none", rdVal);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {24'd0, rdVal}, {24'd0, e});
      end
    end
  end

  initial begin
    #WDOG;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic ack;
    #100; rstN = 1; #100;

    // reset state
    chk("R2 reset ctrl", {lagSel, wrBankSel, rdBankSel, extOscSel}, 0);
    chk("R5 reset sdaOe", sdaOe, 0);
    chk("R3 reset bankA", (bankAOut == '0), 1);
    chk("R3 reset bankB", (bankBOut == '0), 1);

    // full write to bank B, control byte with junk upper bits, 15th byte extra
    busStart();
    sendByte(8'hE8, ack); chk("R1 ack 0x74", ack, 1);
    sendByte(8'hF2, ack); chk("R3 ctrl ack", ack, 1);
    for (int i = 0; i < NCH; i++) begin
      sendByte(8'(8'h11 * (i + 1)), ack);
      chk("R3 data ack", ack, 1);
    end
    sendByte(8'hAA, ack); chk("R7 15th nack", ack, 0);
    busStop();
    chk("R2 wr sel", wrBankSel, 1);
    chk("R2 upper ignored", {lagSel, rdBankSel, extOscSel}, 0);
    for (int n = 1; n <= NCH; n++) chk("R3 bankB channel", chB(n), 8'(8'h11 * n));
    chk("R3 bankA untouched", (bankAOut == '0), 1);
    chk("R7 discarded", chB(1), 8'h11);

    // wrong address (0x75 while pin low)
    busStart();
    sendByte(8'hEA, ack); chk("R6 mismatch nack", ack, 0);
    sendByte(8'h0D, ack); chk("R6 ignored ack", ack, 0);
    sendByte(8'h77, ack);
    busStop();
    chk("R6 ctrl kept", {lagSel, wrBankSel, rdBankSel, extOscSel}, 4'b0100);
    chk("R6 bankB kept", chB(1), 8'h11);
    chk("R6 bankA kept", (bankAOut == '0), 1);

    // pin high: 0x75, ctrl lag+ext, two bytes then STOP
    addrPin = 1;
    busStart();
    sendByte(8'hEA, ack); chk("R1 ack 0x75", ack, 1);
    sendByte(8'h09, ack);
    sendByte(8'h5A, ack);
    sendByte(8'hA5, ack);
    busStop();
    chk("R2 lag/ext set", {lagSel, wrBankSel, rdBankSel, extOscSel}, 4'b1001);
    chk("R8 ch1 kept", chA(1), 8'h5A);
    chk("R8 ch2 kept", chA(2), 8'hA5);
    chk("R8 ch3 unreached", chA(3), 8'h00);
    chk("R3 bankB unchanged", chB(2), 8'h22);

    // partial control byte then STOP
    busStart();
    sendByte(8'hEA, ack);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    busStop();
    chk("R10 partial ctrl", {lagSel, wrBankSel, rdBankSel, extOscSel}, 4'b1001);

    // repeated START mid-byte, then read bank B
    busStart();
    sendByte(8'hEA, ack);
    sendByte(8'h04, ack);
    sendByte(8'h33, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStart();
    sendByte(8'hEB, ack); chk("R1 read ack", ack, 1);
    for (int n = 1; n <= NCH; n++) begin
      expectByte(8'(8'h11 * n), "R4 read bankB");
      recvByte(n == NCH);
    end
    chk("R5 released after nack", sdaOe, 0);
    busStop();
    chk("R9 ch1 written", chA(1), 8'h33);
    chk("R9 ch2 aborted", chA(2), 8'hA5);
    chk("R2 rd sel", {lagSel, wrBankSel, rdBankSel, extOscSel}, 4'b0010);

    // over-read: two bytes past the end
    busStart();
    sendByte(8'hEB, ack);
    for (int n = 1; n <= NCH + 2; n++) begin
      if (n <= NCH) expectByte(8'(8'h11 * n), "R4 read before end");
      else expectByte(8'hFF, "R11 past end");
      recvByte(n == NCH + 2);
    end
    chk("R11 released", sdaOe, 0);
    busStop();

    // control picks write B, read A: read must come from A
    busStart();
    sendByte(8'hEA, ack);
    sendByte(8'h02, ack);
    busStop();
    busStart();
    sendByte(8'hEB, ack);
    expectByte(8'h33, "R4 bankA ch1");
    recvByte(1'b0);
    expectByte(8'hA5, "R4 bankA ch2");
    recvByte(1'b0);
    expectByte(8'h00, "R4 bankA ch3");
    recvByte(1'b1);
    chk("R5 released", sdaOe, 0);
    busStop();

    #200;
    chk("R4 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule